// File: doc/BRIEF.md
# Inverter Leg Dead-Time and Pulse Qualification Controller

This block sits between a PWM generator and the gate drivers of one half-bridge leg. It takes two separate requests, one for the upper switch and one for the lower switch, and produces the two gate enables. A finite state machine ensures that the two enables are never high together. Whenever conduction moves from one switch to the other, both enables are held low for a programmed number of clock cycles before the incoming switch turns on.

Before the state machine sees the requests, they pass through a multi-stage synchronizer and a width qualifier. A request level that does not stay stable for a programmed number of cycles is discarded, so short pulses and short notches cause no switching at all. If both requests are accepted as active at the same time, the pattern is illegal. Both enables go low, and a one-cycle fault pulse is raised for each such episode.

The dead-time and minimum-width counts are inputs, so firmware or a neighbouring block can retune them at run time. A programmed value of zero counts as one cycle.

Top module: `leg_deadtime_ctrl`

## Requirements
- R1: While and right after the synchronous reset (rst high), gate_hi, gate_lo and fault are all low.
- R2: gate_hi and gate_lo are never high in the same clock cycle.
- R3: When the accepted command moves directly from upper (req_hi=1, req_lo=0) to lower (req_hi=0, req_lo=1), or the other way round, both gates are low for exactly max(dead_cycles,1) cycles before the incoming gate rises.
- R4: A request level held for fewer than max(min_width,1) consecutive cycles is ignored: the gates do not change.
- R5: A request level held for exactly max(min_width,1) consecutive cycles is accepted. For example, an upper pulse of that length, with a dead time shorter than it, produces one gate_hi pulse.
- R6: While an upper request is accepted and gate_hi is high, a low notch on req_hi shorter than max(min_width,1) cycles leaves gate_hi high without interruption.
- R7: While both requests are accepted as active (req_hi=1, req_lo=1), both gates are low.
- R8: fault is high for exactly one cycle for each episode in which both requests become accepted as active, and is low otherwise.
- R9: If the accepted request for the incoming switch is withdrawn before its dead-time interval ends, the incoming gate never rises and both gates return to low.
- R10: A steady accepted upper request drives gate_hi high and gate_lo low. A steady accepted lower request drives gate_lo high and gate_hi low. No accepted request drives both gates low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_hi | input | 1 | Request to turn on the upper switch (asynchronous) |
| req_lo | input | 1 | Request to turn on the lower switch (asynchronous) |
| dead_cycles | input | CNT_W | Blanking length in clock cycles (0 counts as 1) |
| min_width | input | CNT_W | Minimum stable request length in cycles (0 counts as 1) |
| gate_hi | output | 1 | Upper switch gate enable |
| gate_lo | output | 1 | Lower switch gate enable |
| fault | output | 1 | One-cycle pulse when both requests become active together |

## Verification
The bench builds the block with CNT_W=4 and SYNC_STAGES=3. The narrow counter makes the largest programmable dead time and minimum width (15 cycles) reachable in a short run, so the saturating width counter and the longest blanking are exercised next to zero and small values. The three-stage synchronizer checks that acceptance timing depends only on how long a level is held, and not on the synchronizer depth. A 12-cycle dead time paired with a shorter accepted pulse exposes the withdraw-during-blanking path.

// File: rtl/leg_dt_pkg.sv
package leg_dt_pkg;

   typedef enum logic [2:0] {
      ST_OFF     = 3'd0,
      ST_UP_ON   = 3'd1,
      ST_DEAD_LO = 3'd2,
      ST_LO_ON   = 3'd3,
      ST_DEAD_UP = 3'd4
   } leg_state_e;

   // command encoding: bit 1 = upper request, bit 0 = lower request
   localparam logic [1:0] CMD_NONE = 2'b00;
   localparam logic [1:0] CMD_LO   = 2'b01;
   localparam logic [1:0] CMD_UP   = 2'b10;
   localparam logic [1:0] CMD_BAD  = 2'b11;

endpackage

// File: rtl/leg_req_sync.sv
module leg_req_sync #(
   parameter int STAGES = 2
) (
   input  logic       clk,
   input  logic       rst,
   input  logic [1:0] d,
   output logic [1:0] q
);
   logic [1:0] stg [STAGES];

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (rst) stg[0] <= '0;
               else     stg[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (rst) stg[i] <= '0;
               else     stg[i] <= stg[i-1];
            end
         end
      end
   endgenerate

   assign q = stg[STAGES-1];
endmodule

// File: rtl/leg_req_qual.sv
module leg_req_qual #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [1:0]       s_req,
   input  logic [CNT_W-1:0] min_width,
   output logic [1:0]       cmd
);
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [1:0]       cand;
   logic [CNT_W-1:0] run;
   logic [CNT_W-1:0] mw_eff;

   assign mw_eff = (min_width == '0) ? CNT_ONE : min_width;

   always_ff @(posedge clk) begin
      if (rst) begin
         cand <= '0;
         run  <= '0;
         cmd  <= '0;
      end else begin
         if (s_req != cand) begin
            cand <= s_req;
            run  <= CNT_ONE;
         end else if (run != CNT_MAX) begin
            run <= run + CNT_ONE;
         end
         if (run >= mw_eff) cmd <= cand;
      end
   end
endmodule

// File: rtl/leg_fsm.sv
module leg_fsm
   import leg_dt_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [1:0]       cmd,
   input  logic [CNT_W-1:0] dead_cycles,
   output logic             gate_hi,
   output logic             gate_lo,
   output logic             fault
);
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   leg_state_e       state, state_n;
   logic [CNT_W-1:0] dcnt;
   logic [CNT_W-1:0] dead_eff;
   logic             bad_seen;

   assign dead_eff = (dead_cycles == '0) ? CNT_ONE : dead_cycles;

   always_comb begin
      state_n = state;
      unique case (state)
         ST_OFF: begin
            if (cmd == CMD_UP)      state_n = ST_DEAD_UP;
            else if (cmd == CMD_LO) state_n = ST_DEAD_LO;
         end
         ST_DEAD_UP: begin
            if (cmd != CMD_UP)          state_n = ST_OFF;
            else if (dcnt >= dead_eff)  state_n = ST_UP_ON;
         end
         ST_UP_ON: begin
            if (cmd == CMD_LO)      state_n = ST_DEAD_LO;
            else if (cmd != CMD_UP) state_n = ST_OFF;
         end
         ST_DEAD_LO: begin
            if (cmd != CMD_LO)          state_n = ST_OFF;
            else if (dcnt >= dead_eff)  state_n = ST_LO_ON;
         end
         ST_LO_ON: begin
            if (cmd == CMD_UP)      state_n = ST_DEAD_UP;
            else if (cmd != CMD_LO) state_n = ST_OFF;
         end
         default: state_n = ST_OFF;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state    <= ST_OFF;
         dcnt     <= '0;
         bad_seen <= 1'b0;
         fault    <= 1'b0;
      end else begin
         state <= state_n;
         if (state_n != state)    dcnt <= CNT_ONE;
         else if (dcnt != CNT_MAX) dcnt <= dcnt + CNT_ONE;
         bad_seen <= (cmd == CMD_BAD);
         fault    <= (cmd == CMD_BAD) && !bad_seen;
      end
   end

   assign gate_hi = (state == ST_UP_ON);
   assign gate_lo = (state == ST_LO_ON);
endmodule

// File: rtl/leg_deadtime_ctrl.sv
module leg_deadtime_ctrl #(
   parameter int CNT_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             req_hi,
   input  logic             req_lo,
   input  logic [CNT_W-1:0] dead_cycles,
   input  logic [CNT_W-1:0] min_width,
   output logic             gate_hi,
   output logic             gate_lo,
   output logic             fault
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (CNT_W < 2 || CNT_W > 24) begin : g_bad_cnt
         $error("CNT_W must lie in 2..24");
      end
   endgenerate

   logic [1:0] s_req;
   logic [1:0] cmd;

   leg_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   ({req_hi, req_lo}),
      .q   (s_req)
   );

   leg_req_qual #(.CNT_W(CNT_W)) u_qual (
      .clk       (clk),
      .rst       (rst),
      .s_req     (s_req),
      .min_width (min_width),
      .cmd       (cmd)
   );

   leg_fsm #(.CNT_W(CNT_W)) u_fsm (
      .clk         (clk),
      .rst         (rst),
      .cmd         (cmd),
      .dead_cycles (dead_cycles),
      .gate_hi     (gate_hi),
      .gate_lo     (gate_lo),
      .fault       (fault)
   );
endmodule

// File: rtl/leg_deadtime_chk.sv
module leg_deadtime_chk #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst,
   input logic [CNT_W-1:0] dead_cycles,
   input logic             gate_hi,
   input logic             gate_lo,
   input logic             fault
);
   localparam logic [CNT_W:0] RUN_MAX = '1;

   logic [CNT_W:0]   low_run;
   logic [CNT_W-1:0] dead_eff;

   assign dead_eff = (dead_cycles == '0) ? CNT_W'(1) : dead_cycles;

   always_ff @(posedge clk) begin
      if (rst)                          low_run <= '0;
      else if (gate_hi || gate_lo)      low_run <= '0;
      else if (low_run != RUN_MAX)      low_run <= low_run + 1'b1;
   end

   // R1: outputs quiet after reset
   a_r1_reset_quiet: assert property (@(posedge clk)
      rst |=> (!gate_hi && !gate_lo && !fault));

   // R2: never both on
   a_r2_no_overlap: assert property (@(posedge clk) disable iff (rst)
      !(gate_hi && gate_lo));

   // R3: each turn-on preceded by at least the blanking interval
   a_r3_blank_hi: assert property (@(posedge clk) disable iff (rst)
      $rose(gate_hi) |-> (low_run >= {1'b0, dead_eff}));
   a_r3_blank_lo: assert property (@(posedge clk) disable iff (rst)
      $rose(gate_lo) |-> (low_run >= {1'b0, dead_eff}));

   // R7: illegal pattern leaves both gates off
   a_r7_bad_off: assert property (@(posedge clk) disable iff (rst)
      fault |-> (!gate_hi && !gate_lo));

   // R8: fault lasts a single cycle
   a_r8_fault_pulse: assert property (@(posedge clk) disable iff (rst)
      fault |=> !fault);
endmodule

bind leg_deadtime_ctrl leg_deadtime_chk #(.CNT_W(CNT_W)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .dead_cycles (dead_cycles),
   .gate_hi     (gate_hi),
   .gate_lo     (gate_lo),
   .fault       (fault)
);

// File: tb/leg_deadtime_ctrl_tb_top.sv
`timescale 1ns/1ps
module leg_deadtime_ctrl_tb_top;
   localparam int CNT_W = 4;
   localparam int SYNC  = 3;
   localparam int HOLD  = 30;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic req_hi = 1'b0, req_lo = 1'b0;
   logic [CNT_W-1:0] dead_cycles = 4'd3;
   logic [CNT_W-1:0] min_width   = 4'd4;
   logic gate_hi, gate_lo, fault;

   int total = 0, bad = 0;
   int overlap = 0, rise_hi = 0, rise_lo = 0, last_gap = 0, lowrun = 0, fault_cnt = 0;
   logic ph = 1'b0, pl = 1'b0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   leg_deadtime_ctrl #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC)) dut_i (
      .clk(clk), .rst(rst), .req_hi(req_hi), .req_lo(req_lo),
      .dead_cycles(dead_cycles), .min_width(min_width),
      .gate_hi(gate_hi), .gate_lo(gate_lo), .fault(fault)
   );

   // observation at the falling edge
   always @(negedge clk) begin
      if (!rst) begin
         if (gate_hi && gate_lo) overlap++;
         if ((gate_hi || gate_lo) && !(ph || pl)) last_gap = lowrun;
         if (gate_hi && !ph) rise_hi++;
         if (gate_lo && !pl) rise_lo++;
         if (!gate_hi && !gate_lo) lowrun++; else lowrun = 0;
         if (fault) fault_cnt++;
      end
      ph = gate_hi;
      pl = gate_lo;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic drive(input logic h, input logic l, input int n);
      req_hi = h;
      req_lo = l;
      wait_cyc(n);
   endtask

   // {req_hi, req_lo, exp_hi, exp_lo, exact_gap, fault_delta}
   localparam logic [5:0] VEC [8] = '{
      6'b00_00_0_0,
      6'b10_10_0_0,
      6'b01_01_1_0,
      6'b10_10_1_0,
      6'b00_00_0_0,
      6'b01_01_0_0,
      6'b11_00_0_1,
      6'b00_00_0_0
   };

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int r0, f0;
      wait_cyc(5);
      chk(!gate_hi && !gate_lo && !fault, "R1 in reset", {gate_hi, gate_lo, fault}, 0);
      rst = 1'b0;
      wait_cyc(1);
      chk(!gate_hi && !gate_lo && !fault, "R1 after reset", {gate_hi, gate_lo, fault}, 0);

      // vector walk, dead=3, min_width=4
      for (int i = 0; i < 8; i++) begin
         f0 = fault_cnt;
         drive(VEC[i][5], VEC[i][4], HOLD);
         chk(gate_hi == VEC[i][3], "R10/R7 gate_hi", gate_hi, VEC[i][3]);
         chk(gate_lo == VEC[i][2], "R10/R7 gate_lo", gate_lo, VEC[i][2]);
         if (VEC[i][1]) chk(last_gap == 3, "R3 commutation gap", last_gap, 3);
         chk(fault_cnt - f0 == int'(VEC[i][0]), "R8 fault pulses", fault_cnt - f0, VEC[i][0]);
      end

      // R4: pulse one cycle shorter than min_width
      r0 = rise_hi;
      drive(1'b1, 1'b0, 3);
      drive(1'b0, 1'b0, HOLD);
      chk(rise_hi == r0, "R4 narrow pulse ignored", rise_hi - r0, 0);

      // R5: pulse of exactly min_width
      r0 = rise_hi;
      drive(1'b1, 1'b0, 4);
      drive(1'b0, 1'b0, HOLD);
      chk(rise_hi == r0 + 1, "R5 min-width pulse accepted", rise_hi - r0, 1);
      chk(!gate_hi && !gate_lo, "R5 back off", {gate_hi, gate_lo}, 0);

      // R6: notch shorter than min_width
      drive(1'b1, 1'b0, HOLD);
      r0 = rise_hi;
      drive(1'b0, 1'b0, 3);
      drive(1'b1, 1'b0, HOLD);
      chk(gate_hi && rise_hi == r0, "R6 notch ignored", rise_hi - r0, 0);

      // R9: withdraw during a long blanking interval
      dead_cycles = 4'd12;
      drive(1'b0, 1'b1, 40);
      chk(gate_lo && last_gap == 12, "R3 gap at dead=12", last_gap, 12);
      r0 = rise_hi;
      drive(1'b1, 1'b0, 7);
      drive(1'b0, 1'b0, 40);
      chk(rise_hi == r0, "R9 incoming gate never on", rise_hi - r0, 0);
      chk(!gate_hi && !gate_lo, "R9 returns off", {gate_hi, gate_lo}, 0);

      // R3: zero dead count acts as one cycle
      dead_cycles = 4'd0;
      drive(1'b1, 1'b0, HOLD);
      drive(1'b0, 1'b1, HOLD);
      chk(gate_lo && last_gap == 1, "R3 gap at dead=0", last_gap, 1);

      // largest counts
      dead_cycles = 4'd15;
      min_width   = 4'd15;
      drive(1'b1, 1'b0, 50);
      drive(1'b0, 1'b1, 50);
      chk(gate_lo && last_gap == 15, "R3 gap at dead=15", last_gap, 15);
      drive(1'b0, 1'b0, 50);
      r0 = rise_hi;
      drive(1'b1, 1'b0, 14);
      drive(1'b0, 1'b0, 50);
      chk(rise_hi == r0, "R4 pulse of 14 at width 15", rise_hi - r0, 0);
      drive(1'b1, 1'b0, 50);
      chk(gate_hi && !gate_lo, "R10 steady upper at width 15", {gate_hi, gate_lo}, 2);

      chk(overlap == 0, "R2 no overlap", overlap, 0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule